// File: doc/BRIEF.md
# Successive-Approximation Conversion and Power Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. It watches one asynchronous convert-start line and moves through powered-down, power-up, tracking and converting states. A rising edge while asleep wakes the converter. A falling edge freezes the sampled input and runs ten MSB-first bit decisions. Each decision compares the held input code with a trial code, which stands in for the analog comparator.

When a conversion finishes, the block reads the level of convert-start. A low level sends it back to sleep; a high level keeps it powered and returns it to tracking. The finished result is then offered to a downstream serial shift register. That handoff is held back while the serial port reports a read in progress.

All durations are counted in cycles of the internal clock, and each one is a parameter. The defaults are a power-up of 50 cycles, a conversion of 100 cycles (ten decisions of 10 cycles) and a tracking minimum of 5 cycles. The conversion length must be a multiple of the bit count.

Top module: `adc_seq_core`

## Requirements
- R1: After reset `powerOn`, `tracking`, `converting`, `convDone` and `latchReq` are 0 and `resultCode` is 0. Without a rising edge on `startIn` the block stays powered down and never converts.
- R2: A rising edge on `startIn` while powered down raises `powerOn` on the third clock edge after the input change. `tracking` rises PWRUP_CYC cycles after that.
- R3: A falling edge on `startIn` while tracking, with the tracking minimum met, starts a conversion of CONV_CYC cycles. `convDone` is then high for exactly one cycle, CONV_CYC+3 clock edges after the input change.
- R4: A falling edge that arrives during power-up is remembered. The conversion starts on its own when power-up ends, so `convDone` appears PWRUP_CYC+CONV_CYC+3 edges after the rising input change.
- R5: In the cycle in which `convDone` is high, `powerOn` is 0 if the synchronised `startIn` level was low at the end of the conversion. If that level was high, `powerOn` and `tracking` are both 1.
- R6: `latchReq` pulses for one cycle, one cycle after `convDone`, when `readBusy` is 0. While `readBusy` is 1 the pulse and any change of `resultCode` wait. They occur one cycle after `readBusy` returns to 0.
- R7: `resultCode` is the straight-binary value of `sampleCode` captured on the cycle the conversion starts. Bit 9 is the MSB, one code step equals one LSB, and later changes of `sampleCode` have no effect on it.
- R8: A falling edge that arrives before ACQ_CYC tracking cycles have passed is deferred. `converting` rises ACQ_CYC+1 cycles after tracking began.
- R9: Edges on `startIn` during a conversion are ignored. The conversion ends at the same cycle it would have without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rstN | input | 1 | Active-low asynchronous reset, stands for supply connection |
| startIn | input | 1 | Asynchronous convert-start line |
| sampleCode | input | 10 | Digitised input level presented to the comparator model |
| readBusy | input | 1 | High while the serial port is shifting out a result |
| powerOn | output | 1 | Converter powered (power-up, tracking or converting) |
| tracking | output | 1 | Input in track (acquisition) mode |
| converting | output | 1 | Bit decisions in progress |
| convDone | output | 1 | One-cycle strobe at end of conversion |
| latchReq | output | 1 | One-cycle request to load the result into the shift register |
| resultCode | output | 10 | Result handed to the shift register |

## Verification
Two situations are hardest to reach from the ports. The first is a short start pulse that falls inside the power-up window. The second is a falling edge that lands inside the short tracking window right after a powered conversion. The stimulus reaches the first with a one-cycle-wide start pulse. It reaches the second by keeping the start line high through a conversion and dropping it on the very cycle `convDone` is seen. That fall reaches the control about two cycles into tracking, before the minimum has elapsed. The same powered conversion also toggles the start line and the sample code mid-conversion, to show that neither the end time nor the result moves.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PWRUP = 2'd1,
    ST_TRACK = 2'd2,
    ST_CONV  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadHold;
    logic decide;
    logic finish;
    logic handoff;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut,
  output logic riseOut,
  output logic fallOut
);

  logic [STAGES-1:0] chain;
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      prevQ <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], asyncIn};
      prevQ <= chain[STAGES-1];
    end
  end

  assign syncOut = chain[STAGES-1];
  assign riseOut = chain[STAGES-1] & ~prevQ;
  assign fallOut = ~chain[STAGES-1] & prevQ;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int NBITS     = 10,
  parameter int PWRUP_CYC = 50,
  parameter int CONV_CYC  = 100,
  parameter int ACQ_CYC   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startLvl,
  input  logic       startRise,
  input  logic       startFall,
  input  logic       readBusy,
  output seqStrobe_t strb,
  output logic       powerOn,
  output logic       tracking,
  output logic       converting,
  output logic       convDone
);

  localparam int BIT_CYC = CONV_CYC / NBITS;
  localparam int PC_W = $clog2(PWRUP_CYC + 1);
  localparam int PH_W = $clog2(BIT_CYC + 1);
  localparam int BT_W = $clog2(NBITS + 1);
  localparam int AQ_W = $clog2(ACQ_CYC + 1);
  localparam logic [PC_W-1:0] PWR_LAST = PC_W'(PWRUP_CYC - 1);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(BIT_CYC - 1);
  localparam logic [BT_W-1:0] BIT_LAST = BT_W'(NBITS - 1);
  localparam logic [AQ_W-1:0] ACQ_MIN  = AQ_W'(ACQ_CYC);

  seqState_t stateQ, stateD;
  logic [PC_W-1:0] pwrCntQ;
  logic [PH_W-1:0] phaseQ;
  logic [BT_W-1:0] bitQ;
  logic [AQ_W-1:0] acqQ;
  logic pendQ, pendHandQ, convDoneQ;
  logic pwrDone, acqOk, startConv, decideNow, lastDecide, handoff;

  assign pwrDone    = (stateQ == ST_PWRUP) && (pwrCntQ == PWR_LAST);
  assign acqOk      = (acqQ == ACQ_MIN);
  assign decideNow  = (stateQ == ST_CONV) && (phaseQ == PH_LAST);
  assign lastDecide = decideNow && (bitQ == BIT_LAST);
  assign handoff    = pendHandQ && !readBusy;

  always_comb begin
    startConv = 1'b0;
    stateD    = stateQ;
    unique case (stateQ)
      ST_OFF: begin
        if (startRise) stateD = ST_PWRUP;
      end
      ST_PWRUP: begin
        if (pwrDone) begin
          startConv = pendQ || startFall;
          stateD    = startConv ? ST_CONV : ST_TRACK;
        end
      end
      ST_TRACK: begin
        startConv = acqOk && (pendQ || startFall);
        if (startConv) stateD = ST_CONV;
      end
      ST_CONV: begin
        if (lastDecide) stateD = startLvl ? ST_TRACK : ST_OFF;
      end
      default: stateD = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_OFF;
      pwrCntQ   <= '0;
      phaseQ    <= '0;
      bitQ      <= '0;
      acqQ      <= '0;
      pendQ     <= 1'b0;
      pendHandQ <= 1'b0;
      convDoneQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      pwrCntQ <= (stateQ == ST_PWRUP) ? pwrCntQ + 1'b1 : '0;

      if (stateQ != ST_TRACK) acqQ <= '0;
      else if (!acqOk)        acqQ <= acqQ + 1'b1;

      if (stateQ != ST_CONV) begin
        phaseQ <= '0;
        bitQ   <= '0;
      end else if (phaseQ == PH_LAST) begin
        phaseQ <= '0;
        bitQ   <= bitQ + 1'b1;
      end else begin
        phaseQ <= phaseQ + 1'b1;
      end

      if (startConv || stateQ == ST_OFF || stateQ == ST_CONV) pendQ <= 1'b0;
      else if (startFall)                                     pendQ <= 1'b1;

      if (lastDecide)   pendHandQ <= 1'b1;
      else if (handoff) pendHandQ <= 1'b0;

      convDoneQ <= lastDecide;
    end
  end

  assign strb.loadHold = startConv;
  assign strb.decide   = decideNow;
  assign strb.finish   = lastDecide;
  assign strb.handoff  = handoff;

  assign powerOn    = (stateQ != ST_OFF);
  assign tracking   = (stateQ == ST_TRACK);
  assign converting = (stateQ == ST_CONV);
  assign convDone   = convDoneQ;

  AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!powerOn && !startRise) |=> !powerOn); // R1
  AST_DONE_ENDS_CONV: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> $past(converting)); // R3
  AST_POWER_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (powerOn == $past(startLvl))); // R5
  AST_TRACK_BEFORE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(converting) |-> ($past(stateQ == ST_PWRUP) || $past(acqQ == ACQ_MIN))); // R8

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp import adc_seq_pkg::*; #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [NBITS-1:0] sampleCode,
  output logic [NBITS-1:0] resultCode,
  output logic             latchReq
);

  localparam logic [NBITS-1:0] MSB_MASK = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] holdQ, sarQ, maskQ, doneQ, resultQ;
  logic [NBITS-1:0] trial, nextSar;
  logic latchQ;

  assign trial   = sarQ | maskQ;
  assign nextSar = (holdQ >= trial) ? trial : sarQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= '0;
      sarQ    <= '0;
      maskQ   <= '0;
      doneQ   <= '0;
      resultQ <= '0;
      latchQ  <= 1'b0;
    end else begin
      if (strb.loadHold) begin
        holdQ <= sampleCode;
        sarQ  <= '0;
        maskQ <= MSB_MASK;
      end else if (strb.decide) begin
        sarQ  <= nextSar;
        maskQ <= maskQ >> 1;
      end
      if (strb.finish)  doneQ   <= nextSar;
      if (strb.handoff) resultQ <= doneQ;
      latchQ <= strb.handoff;
    end
  end

  assign resultCode = resultQ;
  assign latchReq   = latchQ;

  AST_RESULT_IS_HELD_CODE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> (doneQ == $past(holdQ))); // R7
  AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    latchReq |=> !latchReq); // R6

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core import adc_seq_pkg::*; #(
  parameter int NBITS       = 10,
  parameter int PWRUP_CYC   = 50,
  parameter int CONV_CYC    = 100,
  parameter int ACQ_CYC     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [NBITS-1:0] sampleCode,
  input  logic             readBusy,
  output logic             powerOn,
  output logic             tracking,
  output logic             converting,
  output logic             convDone,
  output logic             latchReq,
  output logic [NBITS-1:0] resultCode
);

  logic startLvl, startRise, startFall;
  seqStrobe_t strb;

  adc_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(startIn),
    .syncOut(startLvl), .riseOut(startRise), .fallOut(startFall)
  );

  adc_seq_ctrl #(
    .NBITS(NBITS), .PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startLvl(startLvl), .startRise(startRise),
    .startFall(startFall), .readBusy(readBusy), .strb(strb),
    .powerOn(powerOn), .tracking(tracking), .converting(converting),
    .convDone(convDone)
  );

  adc_seq_dp #(.NBITS(NBITS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleCode(sampleCode),
    .resultCode(resultCode), .latchReq(latchReq)
  );

  AST_HANDOFF_WAITS_READ: assert property (@(posedge clk) disable iff (!rstN)
    latchReq |-> !$past(readBusy)); // R6

endmodule

// File: tb/adc_seq_core_tb.sv
module adc_seq_core_tb_top;

  localparam int NB  = 10;
  localparam int PWR = 50;
  localparam int CNV = 100;
  localparam int ACQ = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [NB-1:0] sampleCode = '0;
  logic readBusy = 1'b0;
  logic powerOn, tracking, converting, convDone, latchReq;
  logic [NB-1:0] resultCode;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  adc_seq_core #(.NBITS(NB), .PWRUP_CYC(PWR), .CONV_CYC(CNV), .ACQ_CYC(ACQ)) dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .sampleCode(sampleCode),
    .readBusy(readBusy), .powerOn(powerOn), .tracking(tracking),
    .converting(converting), .convDone(convDone), .latchReq(latchReq),
    .resultCode(resultCode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic waitDone(output int n);
    n = -1;
    for (int i = 1; i <= 4000; i++) begin
      tick();
      if (convDone) begin
        n = i;
        break;
      end
    end
  endtask

  // R1: reset state and no conversion without a rising start edge
  task automatic testReset();
    int seen;
    chk(!powerOn && !tracking && !converting, "R1", "state after reset",
        {powerOn, tracking, converting}, 0);
    chk(!convDone && !latchReq && resultCode == '0, "R1", "outputs after reset",
        resultCode, 0);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      sampleCode = NB'(i * 7);
      tick();
      if (powerOn || convDone || latchReq) seen++;
    end
    chk(seen == 0, "R1", "activity without rising edge", seen, 0);
  endtask

  // R2, R3, R5, R6, R7: powered-down cycle with a long pulse
  task automatic testSleepCycle();
    int n;
    startIn = 1'b1;
    for (int i = 1; i <= PWR + 3; i++) begin
      tick();
      if (i == 2) chk(!powerOn, "R2", "powerOn before sync delay", powerOn, 0);
      if (i == 3) chk(powerOn, "R2", "powerOn after rise", powerOn, 1);
      if (i == PWR + 2) chk(!tracking, "R2", "tracking during power-up", tracking, 0);
      if (i == PWR + 3) chk(tracking, "R2", "tracking after power-up", tracking, 1);
    end
    repeat (10) tick();
    sampleCode = 10'h2A5;
    startIn = 1'b0;
    waitDone(n);
    chk(n == CNV + 3, "R3", "convDone latency", n, CNV + 3);
    chk(!powerOn, "R5", "powered down with start low", powerOn, 0);
    tick();
    chk(!convDone, "R3", "convDone one cycle", convDone, 0);
    chk(latchReq, "R6", "latchReq after convDone", latchReq, 1);
    chk(resultCode == 10'h2A5, "R7", "result of long pulse", resultCode, 10'h2A5);
    tick();
    chk(!latchReq, "R6", "latchReq one cycle", latchReq, 0);
  endtask

  // R4: short pulse, fall inside power-up
  task automatic shortPulse(input logic [NB-1:0] code, output int total);
    int n;
    sampleCode = code;
    startIn = 1'b1;
    tick();
    startIn = 1'b0;
    waitDone(n);
    total = (n < 0) ? n : n + 1;
  endtask

  task automatic testShortPulse();
    int total;
    shortPulse(10'h3FF, total);
    chk(total == PWR + CNV + 3, "R4", "short pulse latency", total, PWR + CNV + 3);
    chk(!powerOn, "R5", "sleep after short pulse", powerOn, 0);
    tick();
    chk(resultCode == 10'h3FF, "R7", "full-scale result", resultCode, 10'h3FF);
  endtask

  // R9, R5, R7, R8: powered mode, ignored edges, deferred start
  task automatic testPoweredMode();
    int n;
    startIn = 1'b1;
    repeat (PWR + 15) tick();
    sampleCode = 10'h000;
    startIn = 1'b0;
    n = -1;
    for (int i = 1; i <= 4000; i++) begin
      tick();
      if (i == 10) sampleCode = 10'h155;
      if (i == 40) startIn = 1'b1;
      if (i == 60) startIn = 1'b0;
      if (i == 70) startIn = 1'b1;
      if (convDone) begin
        n = i;
        break;
      end
    end
    chk(n == CNV + 3, "R9", "end time with mid-conversion edges", n, CNV + 3);
    chk(powerOn && tracking, "R5", "stay powered with start high",
        {powerOn, tracking}, 3);
    startIn = 1'b0;
    n = -1;
    for (int i = 1; i <= 4000; i++) begin
      tick();
      if (i == 1) chk(latchReq && resultCode == 10'h000, "R7",
                      "held code ignores later input", resultCode, 0);
      if (i == ACQ) chk(!converting, "R8", "early fall deferred", converting, 0);
      if (i == ACQ + 1) chk(converting, "R8", "deferred start", converting, 1);
      if (convDone) begin
        n = i;
        break;
      end
    end
    chk(n == ACQ + 1 + CNV, "R8", "deferred convDone latency", n, ACQ + 1 + CNV);
    chk(!powerOn, "R5", "sleep after deferred conversion", powerOn, 0);
    tick();
    chk(resultCode == 10'h155, "R7", "deferred result", resultCode, 10'h155);
  endtask

  // R6: handoff waits for the serial read
  task automatic testBusyRead();
    int total;
    int bad;
    readBusy = 1'b1;
    shortPulse(10'h0F0, total);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (latchReq || resultCode != 10'h155) bad++;
    end
    chk(bad == 0, "R6", "no handoff while busy", bad, 0);
    readBusy = 1'b0;
    tick();
    chk(latchReq && resultCode == 10'h0F0, "R6", "handoff after read",
        resultCode, 10'h0F0);
    tick();
    chk(!latchReq, "R6", "single handoff pulse", latchReq, 0);
  endtask

  // R7: straight-binary codes across the range
  task automatic testCodes();
    logic [NB-1:0] codes [4];
    int total;
    codes[0] = 10'h001;
    codes[1] = 10'h200;
    codes[2] = 10'h1FF;
    codes[3] = 10'h3FE;
    for (int k = 0; k < 4; k++) begin
      shortPulse(codes[k], total);
      tick();
      chk(resultCode == codes[k], "R7", "binary code", resultCode, codes[k]);
      repeat (3) tick();
    end
  endtask

  initial begin
    repeat (5) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testSleepCycle();
    testShortPulse();
    testPoweredMode();
    testBusyRead();
    testCodes();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule